// File: doc/BRIEF.md
# I2S Serial Clock Generator

This block runs on the master audio clock and derives from it the two clocks of an I2S link: the bit clock and the frame (left/right) clock. Two dividers are chained. The first divides the master clock by 2 or 4 to make the bit clock. The second counts bit clocks, 32, 64 or 128 per frame, to make the frame clock. One frame-clock period carries one stereo sample, so the frame clock runs at the sample rate. Next to the two clocks, the block gives the serializers a one-cycle strobe at the start of each frame and one-cycle enables on each falling and each rising bit-clock edge.

Software can set the two ratios in either of two ways. It can write ratio codes directly. It can also hand a total master-to-frame divisor to a built-in selector. The selector searches the legal ratio pairs for one whose product matches the divisor, and reports success or failure. When the link carries full 32-bit slots for both channels, the selector rejects the shortest frame.

The ratios can change only while the dividers are stopped. When the enable input falls, the current frame runs to its end before the dividers stop. Neither clock ever produces a shortened pulse.

Top module: `i2s_clkgen`

## Requirements
- R1: After reset, `sclk`, `lrclk`, `frame_start`, `tx_bit_en`, `rx_bit_en`, `busy`, `req_ok` and `req_fail` are all low. The ratios reset to master/bit = 2 and bit/frame = 64.
- R2: A `cfg_we` pulse while `busy` is low loads `cfg_sdiv_sel` and `cfg_lrdiv_sel`. `cfg_sdiv_sel` selects master/bit: 0 gives 2 and 1 gives 4. `cfg_lrdiv_sel` selects bit/frame: 0 gives 32, 1 gives 64 and 2 gives 128. Code 3 makes the whole write ignored.
- R3: A write of bit/frame code 0 (32) is ignored while `wide_mode` is 1, because two 32-bit slots need at least 64 bit clocks. The same write is accepted while `wide_mode` is 0.
- R4: While running, one `sclk` period is S master cycles, where S is the master/bit ratio. `sclk` is low for the first S/2 cycles and high for the last S/2. `tx_bit_en` is high for the one cycle in which `sclk` falls (the first cycle of each bit). `rx_bit_en` is high for the one cycle in which `sclk` rises.
- R5: One `lrclk` period is S×L master cycles, where L is the bit/frame ratio, so one period carries one stereo sample. `lrclk` is low for the first L/2 bits (left) and high for the last L/2 bits (right). It changes only on a falling edge of `sclk`.
- R6: `frame_start` is high for exactly one cycle at the first bit of each left half-frame, together with `tx_bit_en`. The first pulse falls on the first cycle after `enable` is sampled high while stopped.
- R7: A `req_valid` pulse while stopped runs the selector on `req_div`. It tries master/bit 2 and then 4; within each, it tries bit/frame 32, 64 and 128 in that order. It takes the first pair whose product equals `req_div`, loads that pair and pulses `req_ok` one cycle later. For example, a divisor of 128 gives 2×64, not 4×32.
- R8: While `wide_mode` is 1, the selector skips bit/frame 32. When no pair matches, `req_fail` pulses one cycle later and the ratios stay unchanged.
- R9: While `busy` is high, `cfg_we` is ignored, and a `req_valid` is answered with `req_fail` without changing the ratios.
- R10: When `enable` is low while running, the current frame completes. `busy` falls exactly when the next frame would have begun, and from then on `sclk` and `lrclk` are low.
- R11: When `req_valid` and `cfg_we` arrive in the same cycle, the selector takes priority and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock, the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request for the dividers |
| wide_mode | input | 1 | Two 32-bit slots per frame; forbids bit/frame 32 |
| cfg_we | input | 1 | Direct ratio write strobe |
| cfg_sdiv_sel | input | 1 | Master/bit code for a direct write |
| cfg_lrdiv_sel | input | 2 | Bit/frame code for a direct write |
| req_valid | input | 1 | Selector request strobe |
| req_div | input | 16 | Requested total master/frame divisor |
| req_ok | output | 1 | Selector found and loaded a pair |
| req_fail | output | 1 | Selector found no pair, or the dividers were running |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, low for left and high for right |
| frame_start | output | 1 | One-cycle strobe at the start of each left half-frame |
| tx_bit_en | output | 1 | One-cycle enable on each falling bit-clock edge |
| rx_bit_en | output | 1 | One-cycle enable on each rising bit-clock edge |
| busy | output | 1 | Dividers are running |

## Verification
The bench sweeps every request divisor from 0 to 600 in both slot modes. A selector with the wrong search order would pick 4×32 for 128, and one that ignores the wide rule would accept 64. For each ratio pair it measures whole frames: the master cycles per frame, the bit-clock high time, the right-channel time and the count of bit enables. A swapped ratio or an off-by-one terminal count would show up as a wrong frame length. It also counts the cycles from dropping `enable` to the fall of `busy`. An abrupt stop would truncate the frame and emit a runt. Finally, it sends writes and requests while the dividers run, and with both strobes in the same cycle. A design that let these through would change the frame period in mid-stream or apply the wrong ratios.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;
  localparam int SDIV_BASE      = 2;
  localparam int N_SDIV         = 2;
  localparam int LRDIV_BASE     = 32;
  localparam int N_LRDIV        = 3;
  localparam int SLOT_BITS      = 32;
  localparam int WIDE_MIN_LRDIV = 2 * SLOT_BITS;
  localparam int SDIV_MAX       = SDIV_BASE << (N_SDIV - 1);
  localparam int LRDIV_MAX      = LRDIV_BASE << (N_LRDIV - 1);
  localparam int PCNT_W         = $clog2(SDIV_MAX);
  localparam int BCNT_W         = $clog2(LRDIV_MAX);
  localparam int SSEL_W         = (N_SDIV > 1) ? $clog2(N_SDIV) : 1;
  localparam int LSEL_W         = (N_LRDIV > 1) ? $clog2(N_LRDIV) : 1;

  typedef struct packed {
    logic              found;
    logic [SSEL_W-1:0] s_sel;
    logic [LSEL_W-1:0] l_sel;
  } ratio_pick_t;

  function automatic int sdiv_of(int sel);
    return SDIV_BASE << sel;
  endfunction

  function automatic int lrdiv_of(int sel);
    return LRDIV_BASE << sel;
  endfunction

  // bit/frame code exists and respects the two-full-slot floor
  function automatic logic lr_legal(logic [LSEL_W-1:0] code, logic wide);
    if (int'(code) >= N_LRDIV) return 1'b0;
    if (wide && lrdiv_of(int'(code)) < WIDE_MIN_LRDIV) return 1'b0;
    return 1'b1;
  endfunction

  // first pair in search order whose product equals the request
  function automatic ratio_pick_t pick_ratio(int req, logic wide);
    ratio_pick_t r;
    r = '0;
    for (int s = 0; s < N_SDIV; s++) begin
      for (int l = 0; l < N_LRDIV; l++) begin
        if (!r.found && lr_legal(LSEL_W'(l), wide) &&
            sdiv_of(s) * lrdiv_of(l) == req) begin
          r.found = 1'b1;
          r.s_sel = SSEL_W'(s);
          r.l_sel = LSEL_W'(l);
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/i2s_ratio_sel.sv
module i2s_ratio_sel
  import i2s_clk_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic [REQ_W-1:0] req_div,
  input  logic             wide_mode,
  output ratio_pick_t      pick
);
  assign pick = pick_ratio(int'(req_div), wide_mode);
endmodule

// File: rtl/i2s_ratio_regs.sv
module i2s_ratio_regs
  import i2s_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wide_mode,
  input  logic              cfg_we,
  input  logic [SSEL_W-1:0] cfg_s_sel,
  input  logic [LSEL_W-1:0] cfg_l_sel,
  input  logic              req_valid,
  input  ratio_pick_t       pick,
  output logic [SSEL_W-1:0] s_sel,
  output logic [LSEL_W-1:0] l_sel,
  output logic              req_ok,
  output logic              req_fail
);
  localparam logic [SSEL_W-1:0] S_RST = '0;
  localparam logic [LSEL_W-1:0] L_RST = LSEL_W'(1);

  logic req_take, wr_take;
  assign req_take = req_valid && !busy && pick.found;
  assign wr_take  = cfg_we && !req_valid && !busy && lr_legal(cfg_l_sel, wide_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sel    <= S_RST;
      l_sel    <= L_RST;
      req_ok   <= 1'b0;
      req_fail <= 1'b0;
    end else begin
      req_ok   <= req_take;
      req_fail <= req_valid && !req_take;
      if (req_take) begin
        s_sel <= pick.s_sel;
        l_sel <= pick.l_sel;
      end else if (wr_take) begin
        s_sel <= cfg_s_sel;
        l_sel <= cfg_l_sel;
      end
    end
  end

  AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(s_sel) && $stable(l_sel))); // R9
  AST_OK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |-> $past(req_valid)); // R7
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fail |-> (s_sel == $past(s_sel) && l_sel == $past(l_sel))); // R8
  AST_WIDE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && $past(wide_mode)) |-> (lrdiv_of(int'(l_sel)) >= WIDE_MIN_LRDIV)); // R8
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(l_sel) < N_LRDIV); // R2
endmodule

// File: rtl/i2s_divider.sv
module i2s_divider
  import i2s_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SSEL_W-1:0] s_sel,
  input  logic [LSEL_W-1:0] l_sel,
  output logic              sclk,
  output logic              lrclk,
  output logic              frame_start,
  output logic              tx_bit_en,
  output logic              rx_bit_en,
  output logic              busy
);
  logic [PCNT_W-1:0] pcnt, p_next, p_last_val, p_half;
  logic [BCNT_W-1:0] bcnt, b_next, b_last_val, b_half;
  logic              p_last, b_last, frame_wrap;

  assign p_last_val = PCNT_W'(sdiv_of(int'(s_sel)) - 1);
  assign p_half     = PCNT_W'(sdiv_of(int'(s_sel)) / 2);
  assign b_last_val = BCNT_W'(lrdiv_of(int'(l_sel)) - 1);
  assign b_half     = BCNT_W'(lrdiv_of(int'(l_sel)) / 2);

  assign p_last     = (pcnt == p_last_val);
  assign b_last     = (bcnt == b_last_val);
  assign frame_wrap = p_last && b_last;
  assign p_next     = p_last ? '0 : pcnt + 1'b1;
  assign b_next     = p_last ? (b_last ? '0 : bcnt + 1'b1) : bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pcnt <= '0; bcnt <= '0;
      sclk <= 1'b0; lrclk <= 1'b0; frame_start <= 1'b0;
      tx_bit_en <= 1'b0; rx_bit_en <= 1'b0;
    end else if (!busy) begin
      pcnt <= '0; bcnt <= '0;
      sclk <= 1'b0; lrclk <= 1'b0; rx_bit_en <= 1'b0;
      busy        <= enable;
      frame_start <= enable;
      tx_bit_en   <= enable;
    end else if (frame_wrap && !enable) begin
      busy <= 1'b0; pcnt <= '0; bcnt <= '0;
      sclk <= 1'b0; lrclk <= 1'b0; frame_start <= 1'b0;
      tx_bit_en <= 1'b0; rx_bit_en <= 1'b0;
    end else begin
      pcnt        <= p_next;
      bcnt        <= b_next;
      sclk        <= (p_next >= p_half);
      lrclk       <= (b_next >= b_half);
      frame_start <= frame_wrap;
      tx_bit_en   <= p_last;
      rx_bit_en   <= (p_next == p_half);
    end
  end

  AST_FS_IN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (tx_bit_en && !lrclk && !sclk)); // R6
  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (lrclk != $past(lrclk))) |-> tx_bit_en); // R5
  AST_SCLK_FALL_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $fell(sclk)) |-> tx_bit_en); // R4
  AST_SCLK_RISE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> rx_bit_en); // R4
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sclk && !lrclk && !$past(enable))); // R10
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clk_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wide_mode,
  input  logic             cfg_we,
  input  logic [SSEL_W-1:0] cfg_sdiv_sel,
  input  logic [LSEL_W-1:0] cfg_lrdiv_sel,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_div,
  output logic             req_ok,
  output logic             req_fail,
  output logic             sclk,
  output logic             lrclk,
  output logic             frame_start,
  output logic             tx_bit_en,
  output logic             rx_bit_en,
  output logic             busy
);
  ratio_pick_t       pick;
  logic [SSEL_W-1:0] s_sel;
  logic [LSEL_W-1:0] l_sel;

  i2s_ratio_sel #(.REQ_W(REQ_W)) u_sel (
    .req_div   (req_div),
    .wide_mode (wide_mode),
    .pick      (pick)
  );

  i2s_ratio_regs u_regs (
    .clk       (mclk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wide_mode (wide_mode),
    .cfg_we    (cfg_we),
    .cfg_s_sel (cfg_sdiv_sel),
    .cfg_l_sel (cfg_lrdiv_sel),
    .req_valid (req_valid),
    .pick      (pick),
    .s_sel     (s_sel),
    .l_sel     (l_sel),
    .req_ok    (req_ok),
    .req_fail  (req_fail)
  );

  i2s_divider u_div (
    .clk         (mclk),
    .rst_n       (rst_n),
    .enable      (enable),
    .s_sel       (s_sel),
    .l_sel       (l_sel),
    .sclk        (sclk),
    .lrclk       (lrclk),
    .frame_start (frame_start),
    .tx_bit_en   (tx_bit_en),
    .rx_bit_en   (rx_bit_en),
    .busy        (busy)
  );
endmodule

// File: tb/i2s_clkgen_test.sv
module i2s_clkgen_test;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, wide_mode = 1'b0, cfg_we = 1'b0, req_valid = 1'b0;
  logic        cfg_sdiv_sel = 1'b0;
  logic [1:0]  cfg_lrdiv_sel = 2'd0;
  logic [15:0] req_div = 16'd0;
  logic        req_ok, req_fail, sclk, lrclk, frame_start, tx_bit_en, rx_bit_en, busy;

  int checks = 0, errors = 0, cyc = 0;
  int exp_s = 2, exp_l = 64;

  always #4 mclk = ~mclk;

  i2s_clkgen uut (
    .mclk(mclk), .rst_n(rst_n), .enable(enable), .wide_mode(wide_mode),
    .cfg_we(cfg_we), .cfg_sdiv_sel(cfg_sdiv_sel), .cfg_lrdiv_sel(cfg_lrdiv_sel),
    .req_valid(req_valid), .req_div(req_div), .req_ok(req_ok), .req_fail(req_fail),
    .sclk(sclk), .lrclk(lrclk), .frame_start(frame_start), .tx_bit_en(tx_bit_en),
    .rx_bit_en(rx_bit_en), .busy(busy)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge mclk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent model of the pair search
  function automatic bit model_pick(int d, bit wide, output int s, output int l);
    s = 0; l = 0;
    for (int sv = 2; sv <= 4; sv += 2)
      for (int lv = 32; lv <= 128; lv *= 2)
        if (!(wide && lv < 64) && s == 0 && sv * lv == d) begin s = sv; l = lv; end
    return s != 0;
  endfunction

  task automatic wr(int ss, int ll, bit wide);
    @(negedge mclk);
    cfg_we = 1'b1; cfg_sdiv_sel = ss[0]; cfg_lrdiv_sel = ll[1:0]; wide_mode = wide;
    @(negedge mclk);
    cfg_we = 1'b0;
  endtask

  task automatic ask(int d, bit wide, output bit ok, output bit fail);
    @(negedge mclk);
    req_valid = 1'b1; req_div = d[15:0]; wide_mode = wide;
    @(negedge mclk);
    req_valid = 1'b0;
    ok = req_ok; fail = req_fail;
  endtask

  // run one full frame, check its shape, then stop at the frame boundary
  task automatic measure(string tag, int s, int l);
    int p, cnt, tx, rx, sh, lh, lfirst, k;
    p = s * l;
    @(negedge mclk);
    enable = 1'b1;
    @(negedge mclk);
    chk("R6", {tag, " first frame_start"}, int'(frame_start), 1);
    @(negedge mclk);
    chk("R6", {tag, " strobe width"}, int'(frame_start), 0);
    while (!frame_start) @(negedge mclk);
    cnt = 0; tx = 0; rx = 0; sh = 0; lh = 0; lfirst = 0;
    do begin
      tx += int'(tx_bit_en); rx += int'(rx_bit_en);
      sh += int'(sclk); lh += int'(lrclk);
      if (cnt < p / 2) lfirst += int'(lrclk);
      @(negedge mclk);
      cnt++;
    end while (!frame_start && cnt < 2000);
    chk("R5", {tag, " lrclk period"}, cnt, p);
    chk("R5", {tag, " lrclk high cycles"}, lh, p / 2);
    chk("R5", {tag, " lrclk in left half"}, lfirst, 0);
    chk("R4", {tag, " tx_bit_en count"}, tx, l);
    chk("R4", {tag, " rx_bit_en count"}, rx, l);
    chk("R4", {tag, " sclk high cycles"}, sh, p / 2);
    enable = 1'b0;
    k = 0;
    while (busy && k < 2000) begin @(negedge mclk); k++; end
    chk("R10", {tag, " cycles to stop"}, k, p);
    chk("R10", {tag, " sclk idle"}, int'(sclk), 0);
    chk("R10", {tag, " lrclk idle"}, int'(lrclk), 0);
  endtask

  initial begin
    bit ok, fail, mok;
    int ms, ml;
    repeat (3) @(negedge mclk);
    chk("R1", "sclk in reset", int'(sclk), 0);
    chk("R1", "lrclk in reset", int'(lrclk), 0);
    chk("R1", "strobes in reset", int'(frame_start | tx_bit_en | rx_bit_en), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "req flags in reset", int'(req_ok | req_fail), 0);
    rst_n = 1'b1;
    @(negedge mclk);
    measure("R1 default", 2, 64);

    // R2: every direct write code pair
    for (int ss = 0; ss < 2; ss++)
      for (int ll = 0; ll < 3; ll++) begin
        wr(ss, ll, 1'b0);
        measure("R2 write", 2 << ss, 32 << ll);
      end
    wr(1, 2, 1'b0);
    wr(0, 3, 1'b0);
    measure("R2 code3 ignored", 4, 128);

    // R3: floor in wide mode
    wr(0, 1, 1'b0);
    wr(1, 0, 1'b1);
    measure("R3 wide ignored", 2, 64);
    wr(1, 0, 1'b0);
    measure("R3 narrow accepted", 4, 32);
    exp_s = 4; exp_l = 32;

    // R7 / R8: exhaustive selector sweep
    for (int w = 0; w < 2; w++)
      for (int d = 0; d <= 600; d++) begin
        ask(d, w[0], ok, fail);
        mok = model_pick(d, w[0], ms, ml);
        checks++;
        if (ok != mok || fail != !mok) begin
          errors++;
          $display("FAIL R7/R8 div=%0d wide=%0d: actual ok=%0d fail=%0d expected ok=%0d",
                   d, w, ok, fail, mok);
        end
        if (mok) begin exp_s = ms; exp_l = ml; end
      end
    measure("R7 after sweep", exp_s, exp_l);

    ask(128, 1'b0, ok, fail);
    chk("R7", "128 accepted", int'(ok), 1);
    measure("R7 128 picks 2x64", 2, 64);
    ask(512, 1'b0, ok, fail);
    measure("R7 512 picks 4x128", 4, 128);
    ask(64, 1'b1, ok, fail);
    chk("R8", "64 rejected in wide mode", int'(fail), 1);
    measure("R8 failure keeps ratios", 4, 128);
    ask(64, 1'b0, ok, fail);
    chk("R8", "64 accepted in narrow mode", int'(ok), 1);
    measure("R8 64 picks 2x32", 2, 32);

    // R9: changes while running
    @(negedge mclk);
    enable = 1'b1;
    repeat (10) @(negedge mclk);
    wr(1, 2, 1'b0);
    ask(512, 1'b0, ok, fail);
    chk("R9", "request while busy fails", int'(fail), 1);
    chk("R9", "request while busy no ok", int'(ok), 0);
    enable = 1'b0;
    while (busy) @(negedge mclk);
    measure("R9 ratios held", 2, 32);

    // R11: selector beats write in the same cycle
    @(negedge mclk);
    req_valid = 1'b1; req_div = 16'd512; wide_mode = 1'b0;
    cfg_we = 1'b1; cfg_sdiv_sel = 1'b0; cfg_lrdiv_sel = 2'd0;
    @(negedge mclk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk("R11", "selector ok", int'(req_ok), 1);
    measure("R11 selector wins", 4, 128);

    finish_run();
  end
endmodule